// File: doc/BRIEF.md
# Write-Protected Slave Parameter Store

This block holds the five configuration bytes of a bus slave and services two indexed commands from the command processor. A parameter write names an index and a data byte. A parameter read names an index, and the block returns the stored byte, which the command processor sends after the E4h reply header. After power-on reset, each byte holds its factory default. The slave address, the two local-oscillator table entries and the output configuration byte are also driven out as plain pins for the neighbouring blocks.

Non-volatile programming is slow. Each accepted byte write therefore starts a busy period of `WR_CYCLES` clocks, and no request is taken until it ends. A write of FFh to index FFh locks the store for good. After that, no write is accepted until the next power-on reset. The bus-level reset command does not clear the lock.

Requests use a valid/ready stream, and so do read responses. `req_ready` is low while the store is busy and while a read response is still waiting. A request is taken in the cycle where `req_valid` and `req_ready` are both high. A response stays valid, with its data unchanged, until `rsp_ready` takes it. `req_index` and `req_data` only need to be stable in the cycle where the request is taken.

Top module: `cfg_param_store`

## Requirements
- R1: After reset, the bytes at indices 0 to 4 read 14h, 00h, 0Ah, 1Bh and FFh. `slave_addr` is 14h, both LO entries are 0, `out_cfg` is 0Ah, and `busy` and `locked` are 0.
- R2: An accepted write (`req_write`=1) to index 0 to 4 while unlocked stores the byte. The exported pins show it in the next cycle, and a later read of that index returns it.
- R3: An accepted store write holds `busy` high for exactly `WR_CYCLES` cycles. `req_ready` is low in every busy cycle, so reads and writes wait.
- R4: An accepted read (`req_write`=0) raises `rsp_valid` in the next cycle. `rsp_data` holds the byte at that index. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values and `req_ready` is low.
- R5: A read of any index above 04h returns FFh.
- R6: A write to an index above 04h is ignored: no byte changes and `busy` stays low. This includes index FFh with data other than FFh.
- R7: A write of data FFh to index FFh sets `locked` and does not start a busy period. While `locked` is high, writes are taken but change no byte and leave `busy` low. Reads still work.
- R8: `locked` stays high until `rst_n` is asserted. Reset also brings back all the R1 defaults.
- R9: `lo_hi_entry` is bits 7:4 of the byte at index 1, and `lo_lo_entry` is bits 3:0 of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = parameter write, 0 = parameter read |
| req_index | input | 8 | Parameter index |
| req_data | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Byte read |
| busy | output | 1 | Write latency in progress |
| locked | output | 1 | Store is write-protected |
| slave_addr | output | 8 | Byte at index 0 |
| lo_hi_entry | output | 4 | High LO table entry |
| lo_lo_entry | output | 4 | Low LO table entry |
| out_cfg | output | 8 | Byte at index 2 |

## Verification
Two functions can fall in the same cycle: the end of a write's busy period and a read that was presented during that period. Another pair is a held response and a new request. The bench queues a read directly behind a write. It confirms that `req_ready` stays low for the whole busy period, and that the read returns the newly written byte only after `busy` falls. It also stalls `rsp_ready` while a second request waits, and then checks that the held byte is delivered exactly once and that the scoreboard sees responses in order.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_PARAMS = 5;
  localparam logic [BYTE_W-1:0] LOCK_CODE = 8'hFF;
  localparam logic [BYTE_W-1:0] EMPTY_VAL = 8'hFF;

  function automatic logic [BYTE_W-1:0] param_default(input int idx);
    case (idx)
      0:       return 8'h14;
      1:       return 8'h00;
      2:       return 8'h0A;
      3:       return 8'h1B;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cps_param_bank.sv
module cps_param_bank
  import cps_pkg::*;
#(
  parameter int N = NUM_PARAMS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [BYTE_W-1:0]          rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [N-1:0][BYTE_W-1:0]   bytes_q
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bytes_q[g] <= param_default(g);
      else if (wr_en && (wr_idx == BYTE_W'(g)))
        bytes_q[g] <= wr_data;
    end
  end

  always_comb begin
    if (rd_idx < BYTE_W'(N))
      rd_data = bytes_q[rd_idx[IW-1:0]];
    else
      rd_data = EMPTY_VAL;
  end
endmodule

// File: rtl/cps_write_timer.sv
module cps_write_timer #(
  parameter int WR_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain_q <= '0;
    else if (start)
      remain_q <= CW'(WR_CYCLES);
    else if (remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/cps_lock_latch.sv
module cps_lock_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      locked <= 1'b0;
    else if (set)
      locked <= 1'b1;
  end
endmodule

// File: rtl/cfg_param_store.sv
module cfg_param_store
  import cps_pkg::*;
#(
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_index,
  input  logic [7:0]        req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              busy,
  output logic              locked,
  output logic [7:0]        slave_addr,
  output logic [3:0]        lo_hi_entry,
  output logic [3:0]        lo_lo_entry,
  output logic [7:0]        out_cfg
);
  logic                           take;
  logic                           store_en;
  logic                           lock_set;
  logic                           in_range;
  logic [BYTE_W-1:0]              bank_rd;
  logic [NUM_PARAMS-1:0][BYTE_W-1:0] bank_q;

  assign req_ready = !busy && !rsp_valid;
  assign take      = req_valid && req_ready;
  assign in_range  = req_index < BYTE_W'(NUM_PARAMS);
  assign store_en  = take && req_write && !locked && in_range;
  assign lock_set  = take && req_write && !locked &&
                     (req_index == LOCK_CODE) && (req_data == LOCK_CODE);

  cps_param_bank #(.N(NUM_PARAMS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_en),
    .wr_idx  (req_index),
    .wr_data (req_data),
    .rd_idx  (req_index),
    .rd_data (bank_rd),
    .bytes_q (bank_q)
  );

  cps_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (store_en),
    .busy  (busy)
  );

  cps_lock_latch u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (lock_set),
    .locked (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= bank_rd;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign slave_addr  = bank_q[0];
  assign lo_hi_entry = bank_q[1][7:4];
  assign lo_lo_entry = bank_q[1][3:0];
  assign out_cfg     = bank_q[2];
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       busy,
  input logic       locked,
  input logic [7:0] slave_addr,
  input logic [3:0] lo_hi_entry,
  input logic [3:0] lo_lo_entry,
  input logic [7:0] out_cfg
);
  AST_BUSY_STALLS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R3

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R4

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R8

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(slave_addr) && $stable(lo_hi_entry) &&
                $stable(lo_lo_entry) && $stable(out_cfg))); // R7

  AST_LOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !busy) |=> !busy); // R7
endmodule

bind cfg_param_store cps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .busy(busy), .locked(locked), .slave_addr(slave_addr),
  .lo_hi_entry(lo_hi_entry), .lo_lo_entry(lo_lo_entry), .out_cfg(out_cfg)
);

// File: tb/cfg_param_store_tb.sv
module cfg_param_store_tb;
  localparam int TB_WR = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_index = '0, req_data = '0;
  logic req_ready, rsp_valid, busy, locked;
  logic [7:0] rsp_data, slave_addr, out_cfg;
  logic [3:0] lo_hi_entry, lo_lo_entry;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_param_store #(.WR_CYCLES(TB_WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .locked(locked), .slave_addr(slave_addr),
    .lo_hi_entry(lo_hi_entry), .lo_lo_entry(lo_lo_entry), .out_cfg(out_cfg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: present one request, wait until taken; returns at the next negedge
  task automatic send(input logic wr, input logic [7:0] idx, input logic [7:0] dat,
                      input logic [7:0] exp, input string tag);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_data = dat;
    while (!req_ready) @(negedge clk);
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    send(1'b0, idx, 8'h00, exp, tag);
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] dat);
    send(1'b1, idx, dat, 8'h00, "");
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  // Monitor: the transfer happens at the next posedge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R4 unexpected response", rsp_data, 32'hDEAD);
      else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 locked", locked, 0);
    check("R1 slave_addr", slave_addr, 8'h14);
    check("R1 out_cfg", out_cfg, 8'h0A);
    check("R1 lo entries", {lo_hi_entry, lo_lo_entry}, 8'h00);
    check("R1 req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'd0, 8'h14, "R1 idx0");
    rd(8'd1, 8'h00, "R1 idx1");
    rd(8'd2, 8'h0A, "R1 idx2");
    rd(8'd3, 8'h1B, "R1 idx3");
    rd(8'd4, 8'hFF, "R1 idx4");
    drain();

    // R2/R3 write, busy window, read queued behind it
    wr(8'd0, 8'h11);
    check("R2 slave_addr", slave_addr, 8'h11);
    check("R3 req_ready low", req_ready, 0);
    n = 0;
    req_valid = 1'b1; req_write = 1'b0; req_index = 8'd0;
    while (busy) begin
      if (req_ready) check("R3 ready during busy", req_ready, 0);
      n++; @(negedge clk);
    end
    req_valid = 1'b0;
    check("R3 busy length", n, TB_WR);
    rd(8'd0, 8'h11, "R2 readback idx0");
    drain();

    // R9 nibble export
    wr(8'd1, 8'h53);
    check("R9 lo_hi_entry", lo_hi_entry, 4'h5);
    check("R9 lo_lo_entry", lo_lo_entry, 4'h3);
    while (busy) @(negedge clk);

    // R6 out-of-range write ignored
    wr(8'd7, 8'h22);
    check("R6 no busy idx7", busy, 0);
    wr(8'hFF, 8'h00);
    check("R6 no busy FF/00", busy, 0);
    check("R6 not locked", locked, 0);
    // R5 unused read
    rd(8'd7, 8'hFF, "R5 idx7");
    rd(8'hFF, 8'hFF, "R5 idxFF");
    drain();

    // R4 response hold with stalled consumer
    rsp_ready = 1'b0;
    rd(8'd3, 8'h1B, "R4 held idx3");
    repeat (3) @(negedge clk);
    check("R4 held valid", rsp_valid, 1);
    check("R4 held data", rsp_data, 8'h1B);
    check("R4 ready low while held", req_ready, 0);
    rsp_ready = 1'b1;
    rd(8'd1, 8'h53, "R4 order idx1");
    drain();

    // R7 lock
    wr(8'hFF, 8'hFF);
    check("R7 locked", locked, 1);
    check("R7 lock no busy", busy, 0);
    wr(8'd2, 8'h55);
    check("R7 out_cfg frozen", out_cfg, 8'h0A);
    check("R7 locked write no busy", busy, 0);
    rd(8'd2, 8'h0A, "R7 read while locked");
    drain();
    repeat (5) @(negedge clk);
    check("R8 lock persists", locked, 1);

    // R8 reset clears lock and restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 lock cleared", locked, 0);
    check("R8 slave_addr default", slave_addr, 8'h14);
    check("R8 lo default", {lo_hi_entry, lo_lo_entry}, 8'h00);
    wr(8'd2, 8'h3C);
    check("R8 write after reset", out_cfg, 8'h3C);
    while (busy) @(negedge clk);
    rd(8'd2, 8'h3C, "R8 readback idx2");
    drain();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule